// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block refreshes an eight-digit seven-segment LED display from an eight-entry display memory, lighting one digit at a time. It visits the digits in a fixed scrambled order and leaves a timed dark gap between neighbouring digits. During the gap every digit line and every segment line is off, so segment data from one digit never shows faintly on the next.

For each digit the stored byte becomes segment levels in one of three ways. The low nibble can be shown as a hexadecimal character, or as a Code B character (digits, minus sign, E, H, L, P, blank). Alternatively the whole byte can drive the segments directly (raw mode). Raw mode is chosen per digit by a mask; the hexadecimal/Code B choice applies to every decoded digit. A shutdown input stops the scan and darkens the display. A blank request, raised by the loader while it rewrites all eight digits, darkens the display without disturbing the scan timing. One parameter selects common-anode or common-cathode output levels.

The display memory sits outside the block. The block presents a digit address and reads the stored byte back combinationally in the same cycle.

Top module: `led_scan_mux`

## Requirements
- R1: Digits light in the repeating order 2, 5, 1, 7, 8, 6, 4, 3. Digit n is read from memory address n-1 (`mem_addr`, read back on `mem_data` in the same cycle) and is driven on bit n-1 of `digit_en`.
- R2: After reset is released, the outputs stay dark for `GAP_CYCLES` clocks and then digit 2 lights. Each digit stays lit for `ON_CYCLES` consecutive clocks, and consecutive digits are separated by exactly `GAP_CYCLES` dark clocks. A full frame therefore lasts 8×(ON_CYCLES+GAP_CYCLES) clocks. The outputs are registered, one clock behind the inputs and the scan state.
- R3: At most one digit is lit at any time. Whenever no digit is lit, every segment, including the decimal point, is off.
- R4: One clock after `shutdown` is high, all digit and segment outputs are off, and they stay off while it is held. The scan restarts from its beginning: after release, the outputs are dark for `GAP_CYCLES` clocks and then digit 2 lights.
- R5: With `hex_sel`=1, nibble values 0..15 in bits 3:0 show 0-9, A, b, C, d, E, F. Segment bit positions are a=0, b=1, c=2, d=3, e=4, f=5, g=6, dp=7.
- R6: With `hex_sel`=0, nibble values 0..9 show the digits. Values 10..15 show minus (g only), E, H, L, P and blank.
- R7: In raw mode, stored bit 6 drives a, bit 5 b, bit 4 c, bit 3 e, bit 2 g, bit 1 f and bit 0 d. A 1 lights the segment.
- R8: The decimal point lights when stored bit 7 is 0, in every format.
- R9: Bit n-1 of `raw_mask` puts digit n in raw mode regardless of `hex_sel`. Digits whose bit is 0 follow `hex_sel`.
- R10: One clock after `blank_req` is high, all outputs are off. The scan keeps its timing, so when the request drops within a digit's slot, that same digit lights again on the next clock.
- R11: With `COMMON_ANODE`=1, a lit digit drives 1 and a lit segment drives 0. With `COMMON_ANODE`=0, both levels are inverted, and the off state inverts with them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 3 | Display memory read address (digit number minus one) |
| mem_data | input | 8 | Byte stored at `mem_addr`, valid in the same cycle |
| hex_sel | input | 1 | 1: hexadecimal font, 0: Code B font for decoded digits |
| raw_mask | input | 8 | Per-digit raw segment mode, bit n-1 for digit n |
| shutdown | input | 1 | Stops the scan and turns all outputs off |
| blank_req | input | 1 | Forces all outputs off while the scan keeps running |
| digit_en | output | 8 | Digit drive lines, bit n-1 for digit n, level set by `COMMON_ANODE` |
| seg_out | output | 8 | Segment lines a..g on bits 0..6 and decimal point on bit 7, level set by `COMMON_ANODE` |

## Verification
The bench first checks the scan skeleton with a directed frame walk. It measures the order, on length and gap length of every digit, which tells a wrong order table from an off-by-one in either counter. All sixteen nibble values are then shown in both fonts with random decimal-point bits, followed by walking-one and all-on/all-off raw bytes. These patterns separate a swapped segment wire, a swapped font entry and a wrong decimal-point sense. Random per-digit raw masks, random blank pulses and short shutdowns, checked cycle by cycle against a bench model, tell apart a blank request that stalls the scan from one that only darkens it. They also show whether shutdown restarts the scan at digit 2 after a gap. A second instance with the other polarity must mirror every output bit.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int NUM_DIGITS = 8;
    localparam int DIG_W      = $clog2(NUM_DIGITS);
    localparam int SEG_W      = 8;
    localparam int NIB_W      = 4;

    typedef enum logic {
        PH_GAP = 1'b0,
        PH_ON  = 1'b1
    } scan_phase_e;

    typedef struct packed {
        scan_phase_e          phase;
        logic [DIG_W-1:0]     slot;
    } scan_pos_t;

    // Logical segment levels: 1 = lit. Bit 0 = a ... bit 6 = g, bit 7 = dp.
    typedef struct packed {
        logic dp;
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } seg_lit_t;

    typedef enum logic [1:0] {
        FMT_HEX   = 2'd0,
        FMT_CODEB = 2'd1,
        FMT_RAW   = 2'd2
    } glyph_fmt_e;

    // Scan slot to digit index (digit number minus one); the order is behaviour.
    function automatic logic [DIG_W-1:0] slot_to_digit(input logic [DIG_W-1:0] slot);
        logic [DIG_W-1:0] idx;
        case (slot)
            3'd0:    idx = 3'd1;
            3'd1:    idx = 3'd4;
            3'd2:    idx = 3'd0;
            3'd3:    idx = 3'd6;
            3'd4:    idx = 3'd7;
            3'd5:    idx = 3'd5;
            3'd6:    idx = 3'd3;
            default: idx = 3'd2;
        endcase
        return idx;
    endfunction

    // Seven-segment shapes, bit order {g,f,e,d,c,b,a}.
    function automatic logic [6:0] hex_shape(input logic [NIB_W-1:0] nib);
        logic [6:0] s;
        case (nib)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

    function automatic logic [6:0] codeb_shape(input logic [NIB_W-1:0] nib);
        logic [6:0] s;
        case (nib)
            4'hA:    s = 7'h40;  // minus
            4'hB:    s = 7'h79;  // E
            4'hC:    s = 7'h76;  // H
            4'hD:    s = 7'h38;  // L
            4'hE:    s = 7'h73;  // P
            4'hF:    s = 7'h00;  // blank
            default: s = hex_shape(nib);
        endcase
        return s;
    endfunction

    function automatic seg_lit_t raw_shape(input logic [SEG_W-1:0] byte_in);
        seg_lit_t r;
        r.dp = ~byte_in[7];
        r.a  = byte_in[6];
        r.b  = byte_in[5];
        r.c  = byte_in[4];
        r.e  = byte_in[3];
        r.g  = byte_in[2];
        r.f  = byte_in[1];
        r.d  = byte_in[0];
        return r;
    endfunction

endpackage

// File: rtl/led_scan_glyph.sv
module led_scan_glyph
    import led_scan_pkg::*;
(
    input  logic [SEG_W-1:0] code,
    input  glyph_fmt_e       fmt,
    output seg_lit_t         lit
);

    logic       dp_on;
    logic [6:0] shape;

    assign dp_on = ~code[SEG_W-1];

    always_comb begin
        unique case (fmt)
            FMT_CODEB: shape = codeb_shape(code[NIB_W-1:0]);
            default:   shape = hex_shape(code[NIB_W-1:0]);
        endcase
    end

    always_comb begin
        if (fmt == FMT_RAW) begin
            lit = raw_shape(code);
        end else begin
            lit = {dp_on, shape};
        end
    end

endmodule

// File: rtl/led_scan_timer.sv
module led_scan_timer
    import led_scan_pkg::*;
#(
    parameter int ON_CYCLES  = 32000,
    parameter int GAP_CYCLES = 1000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      halt,
    output scan_pos_t pos
);

    localparam int LONGEST = (ON_CYCLES > GAP_CYCLES) ? ON_CYCLES : GAP_CYCLES;
    localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYCLES - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

    scan_pos_t        pos_q, pos_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_end;

    always_comb begin
        at_end = (pos_q.phase == PH_ON) ? (cnt_q == ON_LAST) : (cnt_q == GAP_LAST);
        pos_d  = pos_q;
        cnt_d  = cnt_q + CNT_W'(1);
        if (at_end) begin
            cnt_d = '0;
            if (pos_q.phase == PH_ON) begin
                pos_d.phase = PH_GAP;
                pos_d.slot  = pos_q.slot + DIG_W'(1);
            end else begin
                pos_d.phase = PH_ON;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            pos_q <= '{phase: PH_GAP, slot: '0};
            cnt_q <= '0;
        end else begin
            pos_q <= pos_d;
            cnt_q <= cnt_d;
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/led_scan_drive.sv
module led_scan_drive
    import led_scan_pkg::*;
#(
    parameter bit COMMON_ANODE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  show,
    input  logic [DIG_W-1:0]      dig_idx,
    input  seg_lit_t              seg_lit,
    output logic [NUM_DIGITS-1:0] digit_en,
    output logic [SEG_W-1:0]      seg_out
);

    logic [NUM_DIGITS-1:0] dig_sel;
    logic [NUM_DIGITS-1:0] dig_q;
    seg_lit_t              seg_q;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
        assign dig_sel[i] = show && (dig_idx == DIG_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dig_q <= '0;
            seg_q <= '0;
        end else begin
            dig_q <= dig_sel;
            seg_q <= show ? seg_lit : '0;
        end
    end

    if (COMMON_ANODE) begin : g_anode
        assign digit_en = dig_q;
        assign seg_out  = ~seg_q;
    end else begin : g_cathode
        assign digit_en = ~dig_q;
        assign seg_out  = seg_q;
    end

endmodule

// File: rtl/led_scan_mux.sv
module led_scan_mux
    import led_scan_pkg::*;
#(
    parameter int ON_CYCLES    = 32000,
    parameter int GAP_CYCLES   = 1000,
    parameter bit COMMON_ANODE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [DIG_W-1:0]      mem_addr,
    input  logic [SEG_W-1:0]      mem_data,
    input  logic                  hex_sel,
    input  logic [NUM_DIGITS-1:0] raw_mask,
    input  logic                  shutdown,
    input  logic                  blank_req,
    output logic [NUM_DIGITS-1:0] digit_en,
    output logic [SEG_W-1:0]      seg_out
);

    scan_pos_t        pos;
    logic [DIG_W-1:0] dig_idx;
    glyph_fmt_e       fmt;
    seg_lit_t         lit;
    logic             show;

    led_scan_timer #(
        .ON_CYCLES (ON_CYCLES),
        .GAP_CYCLES(GAP_CYCLES)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .halt(shutdown),
        .pos (pos)
    );

    assign dig_idx  = slot_to_digit(pos.slot);
    assign mem_addr = dig_idx;

    always_comb begin
        if (raw_mask[dig_idx]) begin
            fmt = FMT_RAW;
        end else if (hex_sel) begin
            fmt = FMT_HEX;
        end else begin
            fmt = FMT_CODEB;
        end
    end

    led_scan_glyph u_glyph (
        .code(mem_data),
        .fmt (fmt),
        .lit (lit)
    );

    assign show = (pos.phase == PH_ON) && !shutdown && !blank_req;

    led_scan_drive #(
        .COMMON_ANODE(COMMON_ANODE)
    ) u_drive (
        .clk     (clk),
        .rst     (rst),
        .show    (show),
        .dig_idx (dig_idx),
        .seg_lit (lit),
        .digit_en(digit_en),
        .seg_out (seg_out)
    );

endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
    parameter int ON_CYCLES    = 32000,
    parameter int GAP_CYCLES   = 1000,
    parameter bit COMMON_ANODE = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mem_addr,
    input logic       shutdown,
    input logic       blank_req,
    input logic [7:0] digit_en,
    input logic [7:0] seg_out
);

    logic [7:0]  dig_lit, seg_lit;
    logic [7:0]  prev_lit, last_lit;
    logic [31:0] dark_run, lit_run;

    assign dig_lit = COMMON_ANODE ? digit_en : ~digit_en;
    assign seg_lit = COMMON_ANODE ? ~seg_out : seg_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lit <= '0;
            last_lit <= '0;
            dark_run <= '0;
            lit_run  <= '0;
        end else begin
            prev_lit <= dig_lit;
            if (dig_lit == '0) begin
                if (dark_run < 32'(GAP_CYCLES)) dark_run <= dark_run + 32'd1;
                lit_run <= '0;
            end else begin
                dark_run <= '0;
                last_lit <= dig_lit;
                lit_run  <= (dig_lit == prev_lit) ? lit_run + 32'd1 : 32'd1;
            end
        end
    end

    // R1
    addr_match_chk: assert property (@(posedge clk) disable iff (rst)
        (dig_lit != 8'h00) |-> (dig_lit == (8'h01 << $past(mem_addr))));

    // R3
    one_digit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_lit));

    // R3
    dark_segs_chk: assert property (@(posedge clk) disable iff (rst)
        (dig_lit == 8'h00) |-> (seg_lit == 8'h00));

    // R2
    min_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (dig_lit != 8'h00 && last_lit != 8'h00 && dig_lit != last_lit)
            |-> (dark_run >= 32'(GAP_CYCLES)));

    // R2
    max_on_chk: assert property (@(posedge clk) disable iff (rst)
        (dig_lit != 8'h00 && dig_lit == prev_lit) |-> (lit_run < 32'(ON_CYCLES)));

    // R4
    shutdown_off_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> (dig_lit == 8'h00 && seg_lit == 8'h00));

    // R10
    blank_off_chk: assert property (@(posedge clk) disable iff (rst)
        blank_req |=> (dig_lit == 8'h00 && seg_lit == 8'h00));

endmodule

bind led_scan_mux led_scan_chk #(
    .ON_CYCLES   (ON_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES),
    .COMMON_ANODE(COMMON_ANODE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .shutdown (shutdown),
    .blank_req(blank_req),
    .digit_en (digit_en),
    .seg_out  (seg_out)
);

// File: tb/tb_led_scan_mux.sv
module tb_led_scan_mux;

    localparam int P = 12;
    localparam int G = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hex_sel = 1'b1;
    logic       shutdown = 1'b0;
    logic       blank_req = 1'b0;
    logic [7:0] raw_mask = 8'h00;
    logic [7:0] mem [8];
    logic [2:0] addr_a, addr_c;
    logic [7:0] data_a, data_c;
    logic [7:0] dig_a, seg_a, dig_c, seg_c;

    assign data_a = mem[addr_a];
    assign data_c = mem[addr_c];

    led_scan_mux #(.ON_CYCLES(P), .GAP_CYCLES(G), .COMMON_ANODE(1'b1)) dut (
        .clk(clk), .rst(rst), .mem_addr(addr_a), .mem_data(data_a),
        .hex_sel(hex_sel), .raw_mask(raw_mask), .shutdown(shutdown),
        .blank_req(blank_req), .digit_en(dig_a), .seg_out(seg_a));

    led_scan_mux #(.ON_CYCLES(P), .GAP_CYCLES(G), .COMMON_ANODE(1'b0)) dut_cc (
        .clk(clk), .rst(rst), .mem_addr(addr_c), .mem_data(data_c),
        .hex_sel(hex_sel), .raw_mask(raw_mask), .shutdown(shutdown),
        .blank_req(blank_req), .digit_en(dig_c), .seg_out(seg_c));

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string req_tag = "R2";

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] digit_of(input int slot);
        case (slot)
            0: return 3'd1;  // digit 2
            1: return 3'd4;  // digit 5
            2: return 3'd0;  // digit 1
            3: return 3'd6;  // digit 7
            4: return 3'd7;  // digit 8
            5: return 3'd5;  // digit 6
            6: return 3'd3;  // digit 4
            default: return 3'd2;  // digit 3
        endcase
    endfunction

    // {g,f,e,d,c,b,a}
    function automatic logic [6:0] tb_hex(input logic [3:0] c);
        case (c)
            4'd0: return 7'b0111111;  4'd1: return 7'b0000110;
            4'd2: return 7'b1011011;  4'd3: return 7'b1001111;
            4'd4: return 7'b1100110;  4'd5: return 7'b1101101;
            4'd6: return 7'b1111101;  4'd7: return 7'b0000111;
            4'd8: return 7'b1111111;  4'd9: return 7'b1101111;
            4'd10: return 7'b1110111; 4'd11: return 7'b1111100;
            4'd12: return 7'b0111001; 4'd13: return 7'b1011110;
            4'd14: return 7'b1111001; default: return 7'b1110001;
        endcase
    endfunction

    function automatic logic [6:0] tb_codeb(input logic [3:0] c);
        case (c)
            4'd10: return 7'b1000000;
            4'd11: return 7'b1111001;
            4'd12: return 7'b1110110;
            4'd13: return 7'b0111000;
            4'd14: return 7'b1110011;
            4'd15: return 7'b0000000;
            default: return tb_hex(c);
        endcase
    endfunction

    // Logical lit vector {dp,g,f,e,d,c,b,a}
    function automatic logic [7:0] expect_lit(input logic [7:0] v, input bit raw, input bit hex);
        if (raw) return {~v[7], v[2], v[1], v[3], v[0], v[4], v[5], v[6]};
        if (hex) return {~v[7], tb_hex(v[3:0])};
        return {~v[7], tb_codeb(v[3:0])};
    endfunction

    // Bench model of the timing rules (R2, R4, R10)
    logic [7:0] exp_dig = 8'h00;
    logic [7:0] exp_seg = 8'h00;
    bit m_on = 1'b0;
    int m_cnt = 0;
    int m_slot = 0;
    bit model_live = 1'b0;

    always @(posedge clk) begin
        logic [2:0] d;
        if (rst || shutdown) begin
            exp_dig = 8'h00; exp_seg = 8'h00;
            m_on = 1'b0; m_cnt = 0; m_slot = 0;
        end else begin
            d = digit_of(m_slot);
            if (m_on && !blank_req) begin
                exp_dig = 8'h01 << d;
                exp_seg = expect_lit(mem[d], raw_mask[d], hex_sel);
            end else begin
                exp_dig = 8'h00; exp_seg = 8'h00;
            end
            if (m_on) begin
                if (m_cnt == P - 1) begin m_on = 1'b0; m_cnt = 0; m_slot = (m_slot + 1) % 8; end
                else m_cnt++;
            end else begin
                if (m_cnt == G - 1) begin m_on = 1'b1; m_cnt = 0; end
                else m_cnt++;
            end
        end
        model_live = 1'b1;
    end

    always @(negedge clk) begin
        if (model_live && !done) begin
            check(dig_a == exp_dig, {req_tag, " digit lines"}, {8'h00, dig_a}, {8'h00, exp_dig});
            check(~seg_a == exp_seg, {req_tag, " segment lines"}, {8'h00, ~seg_a}, {8'h00, exp_seg});
            check(dig_c == ~dig_a && seg_c == ~seg_a, "R11 polarity mirror",
                  {dig_c, seg_c}, {~dig_a, ~seg_a});
        end
    end

    task automatic wait_first_lit(input string req);
        int n;
        n = 0;
        @(negedge clk);
        while (dig_a == 8'h00 && n < 1000) begin n++; @(negedge clk); end
        check(n == G, {req, " dark clocks before first digit"}, 16'(n), 16'(G));
        check(dig_a == 8'h02, {req, " first digit is 2"}, {8'h00, dig_a}, 16'h0002);
    endtask

    task automatic check_frame();
        for (int k = 0; k < 8; k++) begin
            int on_len;
            int off_len;
            logic [7:0] want;
            on_len = 0; off_len = 0;
            want = 8'h01 << digit_of(k);
            check(dig_a == want, "R1 scan order", {8'h00, dig_a}, {8'h00, want});
            while (dig_a == want && on_len < 1000) begin on_len++; @(negedge clk); end
            check(on_len == P, "R2 digit on length", 16'(on_len), 16'(P));
            while (dig_a == 8'h00 && off_len < 1000) begin
                check(seg_a == 8'hFF, "R3 segments off in gap", {8'h00, seg_a}, 16'h00FF);
                off_len++;
                @(negedge clk);
            end
            check(off_len == G, "R2 gap length", 16'(off_len), 16'(G));
        end
    endtask

    initial begin
        void'($urandom(32'd7228));
        for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        // R2 / R11: reset state
        check(dig_a == 8'h00 && seg_a == 8'hFF, "R2 reset outputs off", {dig_a, seg_a}, 16'h00FF);
        check(dig_c == 8'hFF && seg_c == 8'h00, "R11 reset off level inverted", {dig_c, seg_c}, 16'hFF00);
        rst = 1'b0;
        req_tag = "R2";
        wait_first_lit("R2");
        req_tag = "R1";
        check_frame();

        // R5: all hex codes, random DP bits
        req_tag = "R5 hex";
        hex_sel = 1'b1;
        for (int i = 0; i < 8; i++) mem[i] = {1'($urandom), 3'b000, 4'(i)};
        check_frame();
        for (int i = 0; i < 8; i++) mem[i] = {1'($urandom), 3'b101, 4'(i + 8)};
        check_frame();

        // R6: Code B font
        req_tag = "R6 code B";
        hex_sel = 1'b0;
        for (int i = 0; i < 8; i++) mem[i] = {1'($urandom), 3'b000, 4'(i)};
        check_frame();
        for (int i = 0; i < 8; i++) mem[i] = {1'($urandom), 3'b011, 4'(i + 8)};
        check_frame();

        // R8: decimal point sense in both fonts
        req_tag = "R8 decimal point";
        for (int i = 0; i < 8; i++) mem[i] = {i[0], 3'b000, 4'(15 - i)};
        check_frame();
        hex_sel = 1'b1;
        check_frame();

        // R7: raw segments, walking one then extremes
        req_tag = "R7 raw";
        raw_mask = 8'hFF;
        for (int i = 0; i < 8; i++) mem[i] = 8'h01 << i;
        check_frame();
        for (int i = 0; i < 8; i++) mem[i] = i[0] ? 8'h80 : 8'h7F;
        check_frame();

        // R9: per-digit raw mask
        req_tag = "R9 raw mask";
        for (int f = 0; f < 4; f++) begin
            raw_mask = 8'($urandom);
            hex_sel  = 1'($urandom);
            for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
            check_frame();
        end

        // R10: blank request inside a digit slot
        req_tag = "R10 blank";
        blank_req = 1'b1;
        @(negedge clk);
        check(dig_a == 8'h00 && seg_a == 8'hFF, "R10 blanked", {dig_a, seg_a}, 16'h00FF);
        blank_req = 1'b0;
        @(negedge clk);
        check(dig_a == 8'h02, "R10 same digit resumes", {8'h00, dig_a}, 16'h0002);
        for (int c = 0; c < 400; c++) begin
            blank_req = ($urandom_range(0, 9) < 3);
            @(negedge clk);
        end
        blank_req = 1'b0;

        // R4: shutdown mid-scan, memory rewritten meanwhile
        req_tag = "R4 shutdown";
        shutdown = 1'b1;
        @(negedge clk);
        check(dig_a == 8'h00 && seg_a == 8'hFF, "R4 outputs off", {dig_a, seg_a}, 16'h00FF);
        for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
        repeat (20) @(negedge clk);
        shutdown = 1'b0;
        wait_first_lit("R4 restart");
        check_frame();

        // Mixed random run: R3 R9 R10 R4
        req_tag = "R3 R9 R10 R4 random";
        for (int c = 0; c < 1500; c++) begin
            if ($urandom_range(0, 19) == 0) raw_mask = 8'($urandom);
            if ($urandom_range(0, 29) == 0) hex_sel = 1'($urandom);
            if ($urandom_range(0, 9) == 0) mem[$urandom_range(0, 7)] = 8'($urandom);
            blank_req = ($urandom_range(0, 9) == 0);
            shutdown  = ($urandom_range(0, 99) == 0);
            @(negedge clk);
        end
        shutdown = 1'b0;
        blank_req = 1'b0;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule